// File: doc/BRIEF.md
# Serial Converter Sample Reader

This block sits on the host side of a three-wire link to a 16-bit differential successive-approximation converter. A one-cycle `start` request pulls the active-low select line down, which makes the converter sample its input and begin converting. The reader then produces a fixed number of serial clock cycles. During the first of these cycles the converter is still converting, so the reader discards that preamble and a single zero framing bit. It then shifts in the 16 result bits, most significant first, and ignores anything the line carries afterwards.

At the end of the last serial clock cycle the select line is released. The assembled word appears on `sample` as a signed two's-complement value, together with a one-cycle `sample_valid` strobe. Three things are set by parameters: the serial clock rate, given as system clocks per half period; the setup time between the select edge and the first clock rise; and the frame length, with a minimum of 22 clocks. A minimum spacing between accepted requests keeps the conversion rate inside the converter's limit.

Top module: `adc_serial_reader`

## Requirements
- R1: While `rst_n` is low and after reset, `cs_n` is 1, `sclk` is 0, `busy` is 0, `sample_valid` is 0 and `sample` is 0.
- R2: A `start` seen at a clock edge while idle and allowed by the rate limit drives `cs_n` low and `busy` high from that edge. Both hold for exactly SETUP_CYC + 2·HALF_DIV·FRAME_CLKS cycles.
- R3: After `cs_n` falls, `sclk` stays low for SETUP_CYC + HALF_DIV cycles before its first rise.
- R4: During a frame, `sclk` is low for HALF_DIV cycles and then high for HALF_DIV cycles, FRAME_CLKS times. It is low whenever `cs_n` is high.
- R5: Counting serial clock rises from 1, the reader samples `sdi` at rises 7 to 22 and packs them MSB first. The line value at rises 1 to 6, which covers the conversion time and the zero framing bit, does not reach `sample`.
- R6: Line values at rises after the 22nd, which occur in frames longer than 22 clocks, do not reach `sample`.
- R7: `cs_n` returns high at the same edge where `sclk` completes its last low-going transition. `sample_valid` is high for exactly that one cycle, and `sample` then carries the 16-bit two's-complement word that was received.
- R8: A `start` that arrives while `busy` is high has no effect. It does not extend the frame or start another one, and it does not change the result.
- R9: A request is accepted only if at least GAP_CYCLES clock edges have passed since the last accepted request. An earlier request is dropped, not queued.
- R10: `sample` holds its value between completed frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one conversion and readout |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low select; its falling edge starts a conversion |
| sclk | output | 1 | Serial data clock |
| busy | output | 1 | High while a frame is in progress |
| sample | output | DATA_W | Last received word, two's complement |
| sample_valid | output | 1 | One-cycle strobe when a new word is on `sample` |

## Verification
The hardest cases to reach are the ones where the line carries a 1 where the reader should ignore it: before the framing zero, and after the LSB in a frame longer than 22 clocks. A real converter leaves those slots floating or low. The bench therefore uses a frame of 24 clocks and a converter model that can be told to drive ones into both windows, so that an off-by-one in the capture window turns into a wrong sample. The rate limit is tested at its exact boundary: a request comes a few cycles too early, and then `start` is held high so that the bench sees acceptance fall on the first permitted edge.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_SETUP = 2'd1,
    RD_CLOCK = 2'd2
  } rd_state_e;

  // True when rising-edge number idx falls in the data window.
  function automatic logic edge_in_window(input int idx, input int first, input int width);
    return (idx >= first) && (idx < first + width);
  endfunction

  // System clocks from select assertion to select release.
  function automatic int frame_cycles(input int setup, input int half, input int clks);
    return setup + 2 * half * clks;
  endfunction

endpackage

// File: rtl/adc_rd_rate_gate.sv
module adc_rd_rate_gate #(
  parameter int GAP_CYCLES = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic open_o
);
  localparam int CW = $clog2(GAP_CYCLES + 1);

  logic [CW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= CW'(GAP_CYCLES);
    end else if (accept) begin
      since_q <= CW'(1);
    end else if (since_q != CW'(GAP_CYCLES)) begin
      since_q <= since_q + 1'b1;
    end
  end

  assign open_o = (since_q == CW'(GAP_CYCLES));

endmodule

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int HW = $clog2(HALF_DIV + 1);

  logic [HW-1:0] half_q;
  logic          sclk_q;
  logic          half_end;

  assign half_end = (half_q == HW'(HALF_DIV - 1));
  assign rise     = run && !sclk_q && half_end;
  assign fall     = run && sclk_q && half_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      half_q <= '0;
      sclk_q <= 1'b0;
    end else if (half_end) begin
      half_q <= '0;
      sclk_q <= !sclk_q;
    end else begin
      half_q <= half_q + 1'b1;
    end
  end

  assign sclk = sclk_q;

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
  import adc_rd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FRAME_CLKS = 22,
  parameter int FIRST_EDGE = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rise,
  input  logic              sdi,
  output logic [DATA_W-1:0] word,
  output logic              shift_en,
  output logic              last_edge
);
  localparam int EW = $clog2(FRAME_CLKS + 1);

  logic [EW-1:0]     edge_q;
  logic [EW-1:0]     edge_nx;
  logic [DATA_W-1:0] shreg_q;

  assign edge_nx   = edge_q + 1'b1;
  assign shift_en  = rise && edge_in_window(int'(edge_nx), FIRST_EDGE, DATA_W);
  assign last_edge = (edge_q == EW'(FRAME_CLKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
    end else if (clear) begin
      edge_q <= '0;
    end else if (rise) begin
      edge_q <= edge_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else if (shift_en) begin
      shreg_q <= {shreg_q[DATA_W-2:0], sdi};
    end
  end

  assign word = shreg_q;

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FRAME_CLKS = 22,
  parameter int HALF_DIV   = 2,
  parameter int SETUP_CYC  = 2,
  parameter int GAP_CYCLES = 120,
  parameter int LEAD_EDGES = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     sdi,
  output logic                     cs_n,
  output logic                     sclk,
  output logic                     busy,
  output logic signed [DATA_W-1:0] sample,
  output logic                     sample_valid
);
  localparam int FIRST_EDGE = LEAD_EDGES + 1;
  localparam int SW         = $clog2(SETUP_CYC + 1);

  rd_state_e          state_q;
  logic [SW-1:0]      setup_q;
  logic               cs_n_q;
  logic               busy_q;
  logic               valid_q;
  logic [DATA_W-1:0]  sample_q;

  // Named internal events, also observed by the checker.
  logic               gate_open;
  logic               accept;
  logic               run;
  logic               sclk_rise;
  logic               sclk_fall;
  logic               shift_en;
  logic               last_edge;
  logic               release_evt;
  logic [DATA_W-1:0]  rx_word;

  assign accept      = start && (state_q == RD_IDLE) && gate_open;
  assign run         = (state_q == RD_CLOCK);
  assign release_evt = run && sclk_fall && last_edge;

  adc_rd_rate_gate #(.GAP_CYCLES(GAP_CYCLES)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .open_o (gate_open)
  );

  adc_rd_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sclk  (sclk),
    .rise  (sclk_rise),
    .fall  (sclk_fall)
  );

  adc_rd_capture #(
    .DATA_W     (DATA_W),
    .FRAME_CLKS (FRAME_CLKS),
    .FIRST_EDGE (FIRST_EDGE)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .rise      (sclk_rise),
    .sdi       (sdi),
    .word      (rx_word),
    .shift_en  (shift_en),
    .last_edge (last_edge)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RD_IDLE;
      setup_q  <= '0;
      cs_n_q   <= 1'b1;
      busy_q   <= 1'b0;
      valid_q  <= 1'b0;
      sample_q <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        RD_IDLE: begin
          if (accept) begin
            state_q <= RD_SETUP;
            setup_q <= '0;
            cs_n_q  <= 1'b0;
            busy_q  <= 1'b1;
          end
        end
        RD_SETUP: begin
          if (setup_q == SW'(SETUP_CYC - 1)) begin
            state_q <= RD_CLOCK;
          end else begin
            setup_q <= setup_q + 1'b1;
          end
        end
        RD_CLOCK: begin
          if (release_evt) begin
            state_q  <= RD_IDLE;
            cs_n_q   <= 1'b1;
            busy_q   <= 1'b0;
            valid_q  <= 1'b1;
            sample_q <= rx_word;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign cs_n         = cs_n_q;
  assign busy         = busy_q;
  assign sample       = sample_q;
  assign sample_valid = valid_q;

endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk
  import adc_rd_pkg::*;
#(
  parameter int FRAME_CLKS = 22,
  parameter int HALF_DIV   = 2,
  parameter int SETUP_CYC  = 2,
  parameter int GAP_CYCLES = 120
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic sample_valid,
  input logic accept,
  input logic shift_en
);
  localparam int FRAME_CY = frame_cycles(SETUP_CYC, HALF_DIV, FRAME_CLKS);
  localparam int LEAD_CY  = SETUP_CYC + HALF_DIV;

  int   since_acc;
  int   since_cs;
  int   busy_cnt;
  logic acc_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_acc <= 0;
      since_cs  <= 0;
      busy_cnt  <= 0;
      acc_seen  <= 1'b0;
    end else begin
      if (accept) begin
        since_acc <= 1;
        acc_seen  <= 1'b1;
      end else if (since_acc < GAP_CYCLES) begin
        since_acc <= since_acc + 1;
      end
      if (cs_n) since_cs <= 0;
      else if (since_cs < LEAD_CY) since_cs <= since_cs + 1;
      if (!busy) busy_cnt <= 0;
      else busy_cnt <= busy_cnt + 1;
    end
  end

  a_r9_gap_respected: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (!acc_seen || since_acc >= GAP_CYCLES));

  a_r3_setup_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (since_cs >= LEAD_CY));

  a_r4_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r2_frame_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < FRAME_CY));

  a_r2_busy_tracks_select: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  a_r7_strobe_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> sample_valid);

  a_r8_accept_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy);

  a_r5_shift_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (!cs_n && !sclk));

endmodule

bind adc_serial_reader adc_serial_reader_chk #(
  .FRAME_CLKS (FRAME_CLKS),
  .HALF_DIV   (HALF_DIV),
  .SETUP_CYC  (SETUP_CYC),
  .GAP_CYCLES (GAP_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .sclk         (sclk),
  .busy         (busy),
  .sample_valid (sample_valid),
  .accept       (accept),
  .shift_en     (shift_en)
);

// File: tb/adc_serial_reader_tb.sv
module adc_serial_reader_tb;
  localparam int CLK_P  = 10;
  localparam int HALF   = 2;
  localparam int SETUP  = 3;
  localparam int FRAME  = 24;
  localparam int GAP    = 130;
  localparam int FLEN   = SETUP + 2 * HALF * FRAME;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sdi;
  logic cs_n, sclk, busy, sample_valid;
  logic signed [15:0] sample;

  always #(CLK_P / 2) clk = ~clk;

  adc_serial_reader #(
    .DATA_W(16), .FRAME_CLKS(FRAME), .HALF_DIV(HALF),
    .SETUP_CYC(SETUP), .GAP_CYCLES(GAP), .LEAD_EDGES(6)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sdi(sdi),
    .cs_n(cs_n), .sclk(sclk), .busy(busy),
    .sample(sample), .sample_valid(sample_valid)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Converter model: behavioural, driven only by cs_n and sclk.
  logic [15:0] conv_q[$];
  logic [15:0] conv_word = '0;
  int          falls = 0;
  int          frames = 0;
  bit          junk = 1'b0;

  always @(negedge cs_n) begin
    frames++;
    falls = 0;
    if (conv_q.size() > 0) conv_word = conv_q.pop_front();
  end

  always @(negedge sclk) if (!cs_n) falls++;

  always_comb begin
    if (cs_n !== 1'b0)      sdi = 1'bz;
    else if (falls < 5)     sdi = junk ? 1'b1 : 1'bz;
    else if (falls == 5)    sdi = 1'b0;
    else if (falls <= 21)   sdi = conv_word[21 - falls];
    else                    sdi = junk ? 1'b1 : 1'b0;
  end

  // Reference model of the reader.
  logic [15:0] mdl_q[$];
  logic [15:0] exp_word = '0;
  logic [15:0] exp_sample = '0;
  int  t = 0;
  int  el = 0;
  int  last_acc = -1000000;
  int  last_fall_t = 0;
  bit  act = 1'b0;
  bit  exp_valid = 1'b0;
  bit  prev_cs = 1'b1;

  task automatic model_and_compare(input bit s);
    bit was_act;
    bit exp_sclk;
    t++;
    exp_valid = 1'b0;
    was_act = act;
    if (was_act) begin
      el++;
      if (el == FLEN) begin
        act = 1'b0;
        exp_valid = 1'b1;
        exp_sample = exp_word;
      end
    end else if (s && (t - last_acc >= GAP)) begin
      act = 1'b1;
      el = 0;
      last_acc = t;
      if (mdl_q.size() > 0) exp_word = mdl_q.pop_front();
    end
    exp_sclk = act && (el >= SETUP) && (((el - SETUP) % (2 * HALF)) >= HALF);
    chk("R2 cs_n", {31'b0, cs_n}, {31'b0, !act});
    chk("R2 busy", {31'b0, busy}, {31'b0, act});
    if (act && el < SETUP + HALF) chk("R3 sclk setup", {31'b0, sclk}, {31'b0, exp_sclk});
    else chk("R4 sclk", {31'b0, sclk}, {31'b0, exp_sclk});
    chk("R7 sample_valid", {31'b0, sample_valid}, {31'b0, exp_valid});
    if (exp_valid) chk("R7 sample", {16'h0, sample}, {16'h0, exp_sample});
    else chk("R10 sample hold", {16'h0, sample}, {16'h0, exp_sample});
    if (prev_cs && !cs_n) last_fall_t = t;
    prev_cs = cs_n;
  endtask

  task automatic step(input bit s);
    start = s;
    @(posedge clk);
    @(negedge clk);
    model_and_compare(s);
  endtask

  task automatic push_word(input logic [15:0] w);
    conv_q.push_back(w);
    mdl_q.push_back(w);
  endtask

  // One accepted frame, then idle up to the next permitted start.
  task automatic run_frame(input logic [15:0] w, input bit jk, input int x1, input int x2);
    push_word(w);
    junk = jk;
    step(1'b1);
    for (int i = 1; i < GAP; i++) step((i == x1) || (i == x2));
  endtask

  initial begin
    int fr0;
    int acc_t;
    sdi = 1'bz;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 cs_n", {31'b0, cs_n}, 32'd1);
    chk("R1 sclk", {31'b0, sclk}, 32'd0);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 sample_valid", {31'b0, sample_valid}, 32'd0);
    chk("R1 sample", {16'h0, sample}, 32'd0);
    rst_n = 1'b1;
    step(1'b0);
    step(1'b0);

    run_frame(16'h7FFF, 1'b0, -1, -1);
    chk("R5 positive full scale", {16'h0, sample}, 32'h7FFF);
    run_frame(16'h8000, 1'b1, -1, -1);
    chk("R6 negative full scale with noisy line", {16'h0, sample}, 32'h8000);

    fr0 = frames;
    run_frame(16'h0001, 1'b0, 40, 60);
    chk("R8 mid-frame start ignored", 32'(frames - fr0), 32'd1);
    chk("R8 result intact", {16'h0, sample}, 32'h0001);

    fr0 = frames;
    run_frame(16'hFFFF, 1'b1, FLEN - 1, FLEN);
    chk("R8 start at release ignored", 32'(frames - fr0), 32'd1);
    chk("R6 minus one", {16'h0, sample}, 32'hFFFF);

    // R9: early request dropped, held request taken at first allowed edge.
    push_word(16'hA5C3);
    junk = 1'b1;
    step(1'b1);
    acc_t = last_fall_t;
    for (int i = 1; i < 110; i++) step(1'b0);
    fr0 = frames;
    step(1'b1);
    for (int i = 0; i < 5; i++) step(1'b0);
    chk("R9 early start dropped", 32'(frames - fr0), 32'd0);
    push_word(16'h0000);
    begin
      int guard = 0;
      while (cs_n && guard < 100) begin
        step(1'b1);
        guard++;
      end
    end
    step(1'b0);
    chk("R9 accepted on first allowed edge", 32'(last_fall_t - acc_t), 32'(GAP));
    chk("R7 A5C3 result", {16'h0, sample}, 32'hA5C3);
    for (int i = 0; i < GAP; i++) step(1'b0);
    chk("R5 zero result", {16'h0, sample}, 32'h0000);

    run_frame(16'h5A3C, 1'b1, -1, -1);
    chk("R6 pattern result", {16'h0, sample}, 32'h5A3C);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule